// File: doc/BRIEF.md
# Hiccup Overcurrent Protection Sequencer

This block supervises a primary-side flyback controller. It watches two protection inputs: a hard overcurrent flag, raised when the sense-resistor voltage passes the 1 V emergency level (well above the 0.75 V peak limit), and a brownout flag, raised when the feedback pin sources too little current during the on-time. It also watches four digital supply comparators. From these inputs it produces two outputs: an enable for the power-switch gate and an enable for the high-voltage start-up current generator.

One hard overcurrent cycle is taken as a possible disturbance. The block only moves to a warning condition. A second tripping cycle right after it stops the converter. A brownout stops the converter at once. After a stop, the generator stays off while the supply capacitor drains. First the supply must pass below the under-voltage lockout level, which clears the latch. Then it must pass below the low restart level. Only then does charging start again, which gives a slow hiccup cycle. In normal running the generator tops up the supply whenever it sags below the recharge level, and stops once the turn-on level is reached.

Top module: `hiccup_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, gate_en_o is 0 and hvgen_en_o is 1, because the block starts in the charging state.
- R2: In the charging state, hvgen_en_o is 1 and gate_en_o is 0. A high vcc_on_i moves the block to running, and from the next cycle gate_en_o is 1 and hvgen_en_o is 0. A brownout flag while charging has no effect.
- R3: While running, a high vcc_low_i sets hvgen_en_o to 1 from the next cycle. It stays 1 until a cycle after the one in which vcc_on_i is seen high. vcc_on_i wins if both are high.
- R4: A switching cycle that contains a hard overcurrent trip, with no trip in the cycle before it, leaves gate_en_o at 1. A cycle without a trip returns the logic to idle.
- R5: Hard overcurrent trips in two consecutive switching cycles stop the block. From the cycle after the second cycle-end strobe, gate_en_o and hvgen_en_o are both 0.
- R6: After a stop, gate_en_o and hvgen_en_o stay 0 whatever vcc_on_i and vcc_low_i do. A high vcc_uvlo_i clears the latch. A later high vcc_reset_i then restores charging, with hvgen_en_o at 1 from the next cycle.
- R7: A high bo_fault_i while running stops the block from the next cycle. The restart sequence is the same as in R6.
- R8: gate_en_o is 0 in any cycle where vcc_uvlo_i is high. A supply dip below lockout while running, with no fault, returns the block to charging.
- R9: A fault in the same cycle as a high vcc_uvlo_i goes straight to waiting for vcc_reset_i, with hvgen_en_o at 0. The block does not go to charging.
- R10: A trip pulse counts for the switching cycle in which it occurs. This holds wherever the pulse falls between two cycle-end strobes, including the strobe cycle itself. A cycle is closed by the strobe (cyc_end_i high). Leaving the running state clears any warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_trip_i | input | 1 | Hard overcurrent comparator flag, active high |
| bo_fault_i | input | 1 | Brownout flag from on-time sense current check, active high |
| cyc_end_i | input | 1 | One-cycle strobe closing each switching cycle |
| vcc_on_i | input | 1 | Supply at or above turn-on level (~13 V) |
| vcc_low_i | input | 1 | Supply below recharge level (~10.5 V) |
| vcc_uvlo_i | input | 1 | Supply below lockout level (~10 V) |
| vcc_reset_i | input | 1 | Supply below restart level (~5 V) |
| gate_en_o | output | 1 | Switching enable |
| hvgen_en_o | output | 1 | High-voltage start-up generator enable |

## Verification
The overlap of interest is a protection fault and a supply lockout landing in the same clock. Two cases are covered: a second tripping cycle-end strobe, and a brownout pulse, each driven in the very cycle the supply flags drop below lockout. The result must be the drain-wait state, with the generator held off, and never the charging state that a plain lockout would give. A long random phase walks the supply level while trips, strobes and brownouts arrive freely. A behavioural model judges every clock of that phase, so other coincidences are also compared: a trip on the strobe cycle, and turn-on together with recharge.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic [1:0] {
    SUP_CHARGE = 2'd0,
    SUP_RUN    = 2'd1,
    SUP_LATCH  = 2'd2,
    SUP_DRAIN  = 2'd3
  } sup_state_e;

endpackage

// File: rtl/hiccup_trip_filter.sv
module hiccup_trip_filter #(
  parameter int unsigned TRIP_CONFIRM = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic oc_trip_i,
  input  logic bo_fault_i,
  input  logic cyc_end_i,
  output logic fault_o
);

  logic seen_q;
  logic seen_d;
  logic seen_en;
  logic hit;
  logic oc_stop;

  // trip seen since the last strobe (R10)
  always_comb begin
    hit     = seen_q | oc_trip_i;
    seen_en = ~arm_i | cyc_end_i | oc_trip_i;
    seen_d  = arm_i & ~cyc_end_i & oc_trip_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else if (seen_en) begin
      seen_q <= seen_d;
    end
  end

  generate
    if (TRIP_CONFIRM <= 1) begin : g_single
      assign oc_stop = arm_i & cyc_end_i & hit;
    end else begin : g_count
      localparam int unsigned CW = $clog2(TRIP_CONFIRM);
      localparam logic [CW-1:0] LAST = CW'(TRIP_CONFIRM - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          cnt_en;

      // consecutive tripping cycles; nonzero means warning (R4, R5)
      always_comb begin
        cnt_en = ~arm_i | cyc_end_i;
        if (~arm_i | ~hit | (cnt_q == LAST)) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        oc_stop = arm_i & cyc_end_i & hit & (cnt_q == LAST);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (cnt_en) begin
          cnt_q <= cnt_d;
        end
      end
    end
  endgenerate

  assign fault_o = arm_i & (bo_fault_i | oc_stop);

endmodule

// File: rtl/hiccup_hv_keeper.sv
module hiccup_hv_keeper (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic vcc_on_i,
  input  logic vcc_low_i,
  output logic keep_o
);

  logic keep_q;
  logic keep_d;
  logic keep_en;

  // recharge hysteresis while running; turn-on level wins (R3)
  always_comb begin
    keep_en = ~run_i | vcc_on_i | vcc_low_i;
    keep_d  = run_i & ~vcc_on_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q <= 1'b0;
    end else if (keep_en) begin
      keep_q <= keep_d;
    end
  end

  assign keep_o = keep_q;

endmodule

// File: rtl/hiccup_supply_fsm.sv
module hiccup_supply_fsm
  import hiccup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic vcc_on_i,
  input  logic vcc_uvlo_i,
  input  logic vcc_reset_i,
  output logic run_o,
  output logic charge_o,
  output logic gate_en_o
);

  sup_state_e state_q;
  sup_state_e state_d;
  logic       state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SUP_CHARGE: if (vcc_on_i) state_d = SUP_RUN;              // R2
      SUP_RUN: begin
        if (fault_i) begin
          state_d = vcc_uvlo_i ? SUP_DRAIN : SUP_LATCH;         // R9
        end else if (vcc_uvlo_i) begin
          state_d = SUP_CHARGE;                                 // R8
        end
      end
      SUP_LATCH:  if (vcc_uvlo_i) state_d = SUP_DRAIN;          // R6
      SUP_DRAIN:  if (vcc_reset_i) state_d = SUP_CHARGE;        // R6
      default:    state_d = SUP_CHARGE;
    endcase
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SUP_CHARGE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign run_o     = (state_q == SUP_RUN);
  assign charge_o  = (state_q == SUP_CHARGE);
  assign gate_en_o = run_o & ~vcc_uvlo_i;

endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq #(
  parameter int unsigned TRIP_CONFIRM = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_trip_i,
  input  logic bo_fault_i,
  input  logic cyc_end_i,
  input  logic vcc_on_i,
  input  logic vcc_low_i,
  input  logic vcc_uvlo_i,
  input  logic vcc_reset_i,
  output logic gate_en_o,
  output logic hvgen_en_o
);

  logic run;
  logic charge;
  logic fault;
  logic keep;

  hiccup_trip_filter #(
    .TRIP_CONFIRM(TRIP_CONFIRM)
  ) u_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (run),
    .oc_trip_i  (oc_trip_i),
    .bo_fault_i (bo_fault_i),
    .cyc_end_i  (cyc_end_i),
    .fault_o    (fault)
  );

  hiccup_supply_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_i     (fault),
    .vcc_on_i    (vcc_on_i),
    .vcc_uvlo_i  (vcc_uvlo_i),
    .vcc_reset_i (vcc_reset_i),
    .run_o       (run),
    .charge_o    (charge),
    .gate_en_o   (gate_en_o)
  );

  hiccup_hv_keeper u_keep (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .vcc_on_i  (vcc_on_i),
    .vcc_low_i (vcc_low_i),
    .keep_o    (keep)
  );

  assign hvgen_en_o = charge | (run & keep);

endmodule

// File: rtl/hiccup_seq_chk.sv
module hiccup_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic bo_fault_i,
  input logic vcc_on_i,
  input logic vcc_uvlo_i,
  input logic vcc_reset_i,
  input logic gate_en_o,
  input logic hvgen_en_o
);

  AST_UVLO_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_uvlo_i |-> !gate_en_o); // R8

  AST_BO_STOPS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_o && bo_fault_i) |=> !gate_en_o); // R7

  AST_BO_HOLDS_HV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_o && bo_fault_i) |=> !hvgen_en_o); // R7

  AST_CHARGE_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en_o && hvgen_en_o && !vcc_uvlo_i && vcc_on_i) |=> (gate_en_o || vcc_uvlo_i)); // R2

  AST_STOP_KEEPS_HV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en_o && !hvgen_en_o && !vcc_uvlo_i && !vcc_reset_i) |=> !hvgen_en_o); // R6

  AST_TURN_ON_ENDS_RECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_o && vcc_on_i) |=> !hvgen_en_o); // R3

endmodule

bind hiccup_seq hiccup_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bo_fault_i  (bo_fault_i),
  .vcc_on_i    (vcc_on_i),
  .vcc_uvlo_i  (vcc_uvlo_i),
  .vcc_reset_i (vcc_reset_i),
  .gate_en_o   (gate_en_o),
  .hvgen_en_o  (hvgen_en_o)
);

// File: tb/sim_hiccup_seq.sv
`timescale 1ns/1ps
module sim_hiccup_seq;

  localparam int CLK_NS = 10;
  localparam int QTR    = CLK_NS / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc_trip = 1'b0;
  logic bo_fault = 1'b0;
  logic cyc_end = 1'b0;
  logic vcc_on = 1'b0;
  logic vcc_low = 1'b0;
  logic vcc_uvlo = 1'b0;
  logic vcc_reset = 1'b0;
  logic gate_en;
  logic hvgen_en;

  int checks = 0;
  int fails = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #(CLK_NS/2) clk = ~clk;

  hiccup_seq u0 (
    .clk(clk), .rst_n(rst_n), .oc_trip_i(oc_trip), .bo_fault_i(bo_fault),
    .cyc_end_i(cyc_end), .vcc_on_i(vcc_on), .vcc_low_i(vcc_low),
    .vcc_uvlo_i(vcc_uvlo), .vcc_reset_i(vcc_reset),
    .gate_en_o(gate_en), .hvgen_en_o(hvgen_en)
  );

  // behavioural reference: 0 charging, 1 running, 2 stopped, 3 waiting for restart level
  int m_mode;
  int m_trips;
  bit m_pend;
  bit m_top;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_trips = 0; m_pend = 0; m_top = 0;
    end else begin
      int nmode;
      bit stop;
      bit tripped;
      nmode = m_mode;
      stop = 0;
      tripped = m_pend || oc_trip;
      if (m_mode == 1) begin
        if (bo_fault) stop = 1;
        if (cyc_end && tripped && m_trips == 1) stop = 1;
      end
      if (m_mode != 1) begin
        m_trips = 0; m_pend = 0;
      end else if (cyc_end) begin
        m_pend = 0;
        m_trips = (tripped && !stop) ? m_trips + 1 : 0;
      end else if (oc_trip) begin
        m_pend = 1;
      end
      if (m_mode != 1 || vcc_on) m_top = 0;
      else if (vcc_low) m_top = 1;
      case (m_mode)
        0: if (vcc_on) nmode = 1;
        1: if (stop) nmode = vcc_uvlo ? 3 : 2;
           else if (vcc_uvlo) nmode = 0;
        2: if (vcc_uvlo) nmode = 3;
        default: if (vcc_reset) nmode = 0;
      endcase
      m_mode = nmode;
    end
  end

  task automatic check(string req, logic act_g, logic exp_g, logic act_h, logic exp_h);
    checks++;
    if (act_g !== exp_g || act_h !== exp_h) begin
      fails++;
      $display("FAIL %s gate_en=%0b exp %0b hvgen_en=%0b exp %0b at %0t",
               req, act_g, exp_g, act_h, exp_h, $time);
    end
  endtask

  always @(posedge clk) begin
    #(QTR);
    if (chk_on && rst_n && !done)
      check(cur_req, gate_en, (m_mode == 1) && !vcc_uvlo,
            hvgen_en, (m_mode == 0) || (m_mode == 1 && m_top));
  end

  task automatic set_lvl(int v);
    vcc_on    = (v >= 13);
    vcc_low   = (v < 11);
    vcc_uvlo  = (v < 10);
    vcc_reset = (v < 5);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lvl_step(int v, int n);
    @(negedge clk); set_lvl(v); cyc(n);
  endtask

  task automatic sw_cycle(int len, int trip_pos);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      oc_trip = (i == trip_pos);
      cyc_end = (i == len - 1);
    end
    @(negedge clk);
    oc_trip = 0; cyc_end = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lvl;
    set_lvl(0);
    cyc(3);
    check("R1", gate_en, 0, hvgen_en, 1);
    @(negedge clk); rst_n = 1; chk_on = 1;
    @(posedge clk); #(QTR);
    check("R1", gate_en, 0, hvgen_en, 1);

    cur_req = "R2";
    lvl_step(8, 3);
    check("R2", gate_en, 0, hvgen_en, 1);
    bo_fault = 1; cyc(1); bo_fault = 0; cyc(1);
    check("R2", gate_en, 0, hvgen_en, 1);
    lvl_step(13, 1);
    check("R2", gate_en, 1, hvgen_en, 0);

    cur_req = "R3";
    lvl_step(12, 3);
    check("R3", gate_en, 1, hvgen_en, 0);
    lvl_step(10, 1);
    check("R3", gate_en, 1, hvgen_en, 1);
    lvl_step(12, 4);
    check("R3", gate_en, 1, hvgen_en, 1);
    lvl_step(13, 1);
    check("R3", gate_en, 1, hvgen_en, 0);
    lvl_step(12, 2);

    cur_req = "R4";
    sw_cycle(5, 2);
    check("R4", gate_en, 1, hvgen_en, 0);
    sw_cycle(5, -1);
    sw_cycle(5, 1);
    check("R4", gate_en, 1, hvgen_en, 0);
    sw_cycle(5, -1);
    cur_req = "R10";
    sw_cycle(4, 0);
    check("R10", gate_en, 1, hvgen_en, 0);
    cur_req = "R5";
    sw_cycle(6, 5);
    check("R5", gate_en, 0, hvgen_en, 0);

    cur_req = "R6";
    lvl_step(13, 4);
    check("R6", gate_en, 0, hvgen_en, 0);
    lvl_step(10, 3);
    check("R6", gate_en, 0, hvgen_en, 0);
    lvl_step(9, 2);
    check("R6", gate_en, 0, hvgen_en, 0);
    lvl_step(6, 3);
    check("R6", gate_en, 0, hvgen_en, 0);
    lvl_step(4, 1);
    check("R6", gate_en, 0, hvgen_en, 1);
    lvl_step(13, 1);
    check("R6", gate_en, 1, hvgen_en, 0);
    lvl_step(12, 1);

    cur_req = "R7";
    @(negedge clk); bo_fault = 1;
    @(negedge clk); bo_fault = 0;
    check("R7", gate_en, 0, hvgen_en, 0);
    lvl_step(9, 2); lvl_step(3, 1);
    check("R7", gate_en, 0, hvgen_en, 1);
    lvl_step(13, 1); lvl_step(12, 1);

    cur_req = "R8";
    @(negedge clk); set_lvl(9); #1;
    check("R8", gate_en, 0, hvgen_en, 0);
    cyc(1);
    check("R8", gate_en, 0, hvgen_en, 1);
    lvl_step(13, 1); lvl_step(12, 1);

    cur_req = "R9";
    sw_cycle(5, 2);
    @(negedge clk); oc_trip = 1; cyc_end = 1; set_lvl(9);
    @(negedge clk); oc_trip = 0; cyc_end = 0;
    check("R9", gate_en, 0, hvgen_en, 0);
    cyc(3);
    check("R9", gate_en, 0, hvgen_en, 0);
    lvl_step(3, 1); lvl_step(13, 1); lvl_step(12, 1);
    @(negedge clk); bo_fault = 1; set_lvl(9);
    @(negedge clk); bo_fault = 0;
    check("R9", gate_en, 0, hvgen_en, 0);
    lvl_step(3, 1); lvl_step(13, 1); lvl_step(12, 1);

    cur_req = "R10";
    sw_cycle(5, 2);
    lvl_step(9, 2);
    lvl_step(13, 1); lvl_step(12, 1);
    sw_cycle(5, 2);
    check("R10", gate_en, 1, hvgen_en, 0);

    cur_req = "R5";
    lvl = 12;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (($urandom % 4) == 0) begin
        lvl = lvl + int'($urandom % 3) - 1;
        if (lvl < 0) lvl = 0;
        if (lvl > 15) lvl = 15;
      end
      if (($urandom % 400) == 0) lvl = 2;
      set_lvl(lvl);
      oc_trip  = (($urandom % 8) == 0);
      cyc_end  = (($urandom % 5) == 0);
      bo_fault = (($urandom % 300) == 0);
    end
    @(negedge clk);
    oc_trip = 0; cyc_end = 0; bo_fault = 0;
    cyc(2);
    finish_run();
  end

endmodule